// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table and the small register port that fills it. Software reaches the port through a 32-bit bus with a 16-byte window. Only aligned full-word writes have an effect. A write to the index register picks the entry to be loaded. Each write to the data register then supplies one colour component, taken from the most significant byte of the word. The components are stored in red, green, blue order into the selected entry. After the blue component the index steps to the next entry, so a whole table can be streamed with one index write followed by a run of data writes.

A pixel pipeline reads the table through a separate synchronous lookup port. It presents an 8-bit index and receives the packed 24-bit colour one clock later. The component sequencer has three states, `PH_RED`, `PH_GREEN` and `PH_BLUE`. The transitions are:
- `PH_RED` to `PH_GREEN` on a data write.
- `PH_GREEN` to `PH_BLUE` on a data write.
- `PH_BLUE` to `PH_RED` on a data write, which also steps the index.
- Any state to `PH_RED` on an index write.
- All states hold when there is no accepted write.

Top module: `clut_loader`

## Requirements
- R1: After reset, every table entry reads 24'h000000 except entry 255, which reads 24'hFFFFFF. The index is 0 and the sequencer is in `PH_RED`, so the first data write lands in the red byte of entry 0.
- R2: A write to offset 0 with all four byte enables set loads the index from wdata[31:24] and puts the sequencer in `PH_RED`.
- R3: A write to offset 4 with all byte enables set stores wdata[31:24] into one component of the current entry. Successive writes go to red (packed bits 23:16), then green (15:8), then blue (7:0). Bits 23:0 of the written word have no effect.
- R4: The data write that stores blue also increments the index modulo 256, so 255 wraps to 0, and returns the sequencer to `PH_RED`.
- R5: A write whose byte enables are not all set changes neither the table, nor the index, nor the sequencer.
- R6: Writes to offsets 8 and 12, and to any offset not a multiple of 4, change neither the table, nor the index, nor the sequencer.
- R7: Bus reads at any offset return 0 and do not advance the sequencer.
- R8: The lookup port returns the entry selected by `lut_idx` on `lut_rgb` one clock after the index is presented, packed as {red, green, blue}.
- R9: A lookup of an entry issued in the same clock as a write to that entry returns the old value. The new value is seen by a lookup issued one clock later.
- R10: An index write in the middle of a component sequence abandons it. The next data write goes to red of the newly loaded entry, and components already stored stay as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_be | input | 4 | Byte enables; all ones = full word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| lut_idx | input | 8 | Lookup index from the pixel pipeline |
| lut_rgb | output | 24 | Looked-up colour {R,G,B}, one cycle late |

## Verification
The bench streams triplets across the index wrap from 255 to 0. A design that skips the wrap, or steps the index on the wrong component, puts later colours in the wrong entries. It reloads the index mid-triplet. A sequencer that is not restarted would write the green or blue byte where red belongs. It sends partial-width writes, writes to the unused offsets and reads to the data offset, then checks where the next component lands. A decoder that is too lax would corrupt entries or silently advance the sequencer. It also issues a lookup in the same cycle as a write to the same entry. A table with a write-through read path would return the new colour one cycle too early.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int unsigned IDX_W    = 8;
    localparam int unsigned COMP_W   = 8;
    localparam int unsigned N_COMP   = 3;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned RGB_W    = N_COMP * COMP_W;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_e;
endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode
    import clut_pkg::*;
#(
    parameter int unsigned A_W = ADDR_W,
    parameter int unsigned D_W = DATA_W,
    parameter int unsigned C_W = COMP_W
) (
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [A_W-1:0] bus_addr,
    input  logic [D_W/8-1:0] bus_be,
    input  logic [D_W-1:0] bus_wdata,
    output logic           idx_load,
    output logic           comp_load,
    output logic [C_W-1:0] wr_byte,
    output logic [D_W-1:0] bus_rdata
);
    localparam logic [A_W-1:0] OFS_INDEX = A_W'(0);
    localparam logic [A_W-1:0] OFS_COMP  = A_W'(4);

    logic full_wr;
    logic unused_low;

    assign full_wr    = bus_sel && bus_we && (&bus_be);
    assign idx_load   = full_wr && (bus_addr == OFS_INDEX);
    assign comp_load  = full_wr && (bus_addr == OFS_COMP);
    assign wr_byte    = bus_wdata[D_W-1 -: C_W];
    assign unused_low = ^bus_wdata[D_W-C_W-1:0];
    assign bus_rdata  = '0;

    always_comb begin
        AST_DECODE_EXCL: assert (!(idx_load && comp_load)); // R6
    end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int unsigned I_W = IDX_W,
    parameter int unsigned C_W = COMP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idx_load,
    input  logic           comp_load,
    input  logic [C_W-1:0] wr_byte,
    output logic [I_W-1:0] wr_idx,
    output logic [N_COMP-1:0] comp_we
);
    comp_phase_e    phase, phase_nx;
    logic [I_W-1:0] cur_idx, idx_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_RED;
            cur_idx <= '0;
        end else begin
            phase   <= phase_nx;
            cur_idx <= idx_nx;
        end
    end

    // next state
    always_comb begin
        phase_nx = phase;
        idx_nx   = cur_idx;
        if (idx_load) begin
            idx_nx   = wr_byte[C_W-1 -: I_W];
            phase_nx = PH_RED;
        end else if (comp_load) begin
            unique case (phase)
                PH_RED:   phase_nx = PH_GREEN;
                PH_GREEN: phase_nx = PH_BLUE;
                PH_BLUE: begin
                    phase_nx = PH_RED;
                    idx_nx   = cur_idx + 1'b1;
                end
                default:  phase_nx = PH_RED;
            endcase
        end
    end

    // outputs: byte-lane write enable, lane 2 = red, lane 0 = blue
    always_comb begin
        comp_we = '0;
        wr_idx  = cur_idx;
        if (comp_load) begin
            unique case (phase)
                PH_RED:   comp_we = 3'b100;
                PH_GREEN: comp_we = 3'b010;
                PH_BLUE:  comp_we = 3'b001;
                default:  comp_we = '0;
            endcase
        end
    end

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3); // R3
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> (cur_idx == $past(wr_byte[C_W-1 -: I_W])) && (phase == PH_RED)); // R2
    AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_load && !idx_load && phase == PH_RED) |=> (phase == PH_GREEN) && $stable(cur_idx)); // R3
    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_load && !idx_load && phase == PH_BLUE) |=>
            (phase == PH_RED) && (cur_idx == $past(cur_idx) + 1'b1)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!comp_load && !idx_load) |=> $stable(cur_idx) && $stable(phase)); // R5
endmodule

// File: rtl/clut_table.sv
module clut_table
    import clut_pkg::*;
#(
    parameter int unsigned I_W = IDX_W,
    parameter int unsigned C_W = COMP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [I_W-1:0] wr_idx,
    input  logic [N_COMP-1:0] comp_we,
    input  logic [C_W-1:0] wr_byte,
    input  logic [I_W-1:0] rd_idx,
    output logic [N_COMP*C_W-1:0] rd_rgb
);
    localparam int unsigned ENTRIES = 1 << I_W;
    localparam int unsigned E_W     = N_COMP * C_W;

    logic [E_W-1:0] tab [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tab[e] <= (e == ENTRIES - 1) ? {E_W{1'b1}} : '0;
            end
            rd_rgb <= '0;
        end else begin
            for (int k = 0; k < N_COMP; k++) begin
                if (comp_we[k]) begin
                    tab[wr_idx][k*C_W +: C_W] <= wr_byte;
                end
            end
            rd_rgb <= tab[rd_idx];
        end
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we)); // R3
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [RGB_W-1:0]  lut_rgb
);
    logic              idx_load;
    logic              comp_load;
    logic [COMP_W-1:0] wr_byte;
    logic [IDX_W-1:0]  wr_idx;
    logic [N_COMP-1:0] comp_we;

    clut_bus_decode #(.A_W(ADDR_W), .D_W(DATA_W), .C_W(COMP_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .idx_load  (idx_load),
        .comp_load (comp_load),
        .wr_byte   (wr_byte),
        .bus_rdata (bus_rdata)
    );

    clut_seq #(.I_W(IDX_W), .C_W(COMP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_load  (idx_load),
        .comp_load (comp_load),
        .wr_byte   (wr_byte),
        .wr_idx    (wr_idx),
        .comp_we   (comp_we)
    );

    clut_table #(.I_W(IDX_W), .C_W(COMP_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_idx  (wr_idx),
        .comp_we (comp_we),
        .wr_byte (wr_byte),
        .rd_idx  (lut_idx),
        .rd_rgb  (lut_rgb)
    );

    AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> $stable(wr_idx)); // R7
endmodule

// File: tb/test_clut_loader.sv
module test_clut_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] m_tab [256];
    logic [7:0]  m_idx;
    int          m_ph;

    always #4 clk = ~clk;

    clut_loader i_clut_loader (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] addr, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_be = be; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (be == 4'hF && addr == 4'd0) begin
            m_idx = data[31:24]; m_ph = 0;
        end else if (be == 4'hF && addr == 4'd4) begin
            m_tab[m_idx][(2-m_ph)*8 +: 8] = data[31:24];
            if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
            else m_ph++;
        end
    endtask

    task automatic peek(input logic [7:0] idx, output logic [23:0] rgb);
        @(negedge clk);
        lut_idx = idx;
        @(negedge clk);
        rgb = lut_rgb;
    endtask

    task automatic chk_entry(input string req, input logic [7:0] idx);
        logic [23:0] v;
        peek(idx, v);
        chk(req, {8'h0, v}, {8'h0, m_tab[idx]});
    endtask

    // the next data write must land in the model's current index and phase
    task automatic chk_position(input string req);
        logic [7:0] where;
        where = m_idx;
        bus_wr(4'd4, 4'hF, 32'h5A00_0000);
        chk_entry(req, where);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        for (int e = 0; e < 256; e++) begin
            peek(e[7:0], v);
            chk("R1 reset table", {8'h0, v}, (e == 255) ? 32'h00FF_FFFF : 32'h0);
        end
        chk_position("R1 reset index/phase");
    endtask

    task automatic t_triplet;
        bus_wr(4'd0, 4'hF, 32'h10AB_CDEF);
        bus_wr(4'd4, 4'hF, 32'h1100_00FF);
        bus_wr(4'd4, 4'hF, 32'h22FF_FF00);
        bus_wr(4'd4, 4'hF, 32'h3312_3456);
        chk_entry("R3 R8 triplet 0x10", 8'h10);
        chk("R3 model packing", {8'h0, m_tab[8'h10]}, 32'h0011_2233);
        chk("R4 index step", {24'h0, m_idx}, 32'h11);
        chk_position("R4 next write at index 0x11 red");
    endtask

    task automatic t_wrap;
        bus_wr(4'd0, 4'hF, 32'hFF00_0000);
        bus_wr(4'd4, 4'hF, 32'h8000_0000);
        bus_wr(4'd4, 4'hF, 32'h4000_0000);
        bus_wr(4'd4, 4'hF, 32'h2000_0000);
        chk_entry("R4 entry 255 written", 8'hFF);
        chk("R4 wrap to 0", {24'h0, m_idx}, 32'h0);
        chk_position("R4 after wrap lands in entry 0");
    endtask

    task automatic t_restart;
        bus_wr(4'd0, 4'hF, 32'h0500_0000);
        bus_wr(4'd4, 4'hF, 32'hA100_0000);
        bus_wr(4'd4, 4'hF, 32'hB200_0000);
        bus_wr(4'd0, 4'hF, 32'h0500_0000);
        bus_wr(4'd4, 4'hF, 32'hC300_0000);
        chk_entry("R10 restart red overwritten, green kept", 8'h05);
        chk("R10 model", {8'h0, m_tab[8'h05]}, 32'h00C3_B200);
        bus_wr(4'd0, 4'hF, 32'h0600_0000);
        bus_wr(4'd4, 4'hF, 32'hD400_0000);
        bus_wr(4'd0, 4'hF, 32'h0700_0000);
        chk_position("R10 reload to new entry starts at red");
        chk_entry("R10 old entry kept", 8'h06);
    endtask

    task automatic t_ignored;
        bus_wr(4'd0, 4'hF, 32'h2000_0000);
        bus_wr(4'd4, 4'hF, 32'h1800_0000);
        bus_wr(4'd4, 4'h7, 32'hEE00_0000);
        bus_wr(4'd4, 4'hE, 32'hEE00_0000);
        bus_wr(4'd0, 4'h8, 32'h9900_0000);
        chk_entry("R5 partial writes no table change", 8'h20);
        chk_position("R5 partial writes no sequencer change");
        bus_wr(4'd8, 4'hF, 32'hEE00_0000);
        bus_wr(4'd12, 4'hF, 32'hEE00_0000);
        bus_wr(4'd5, 4'hF, 32'hEE00_0000);
        bus_wr(4'd1, 4'hF, 32'h9900_0000);
        chk_entry("R6 other offsets no table change", 8'h20);
        chk_position("R6 other offsets no sequencer change");
        chk_entry("R6 entry 0x99 untouched", 8'h99);
        chk_entry("R6 entry 0xEE untouched", 8'hEE);
    endtask

    task automatic t_reads;
        for (int a = 0; a < 16; a += 4) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[3:0]; bus_be = 4'hF;
            bus_wdata = 32'hFFFF_FFFF;
            #1;
            chk("R7 read returns zero", bus_rdata, 32'h0);
        end
        @(negedge clk);
        bus_sel = 1'b0;
        chk_position("R7 reads do not advance sequencer");
    endtask

    task automatic t_same_cycle;
        logic [23:0] old_v;
        logic [7:0]  tgt;
        bus_wr(4'd0, 4'hF, 32'h4000_0000);
        tgt = 8'h40;
        old_v = m_tab[tgt];
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_be = 4'hF;
        bus_wdata = 32'h7700_0000;
        lut_idx = tgt;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R9 same-cycle lookup returns old", {8'h0, lut_rgb}, {8'h0, old_v});
        m_tab[tgt][23:16] = 8'h77; m_ph = 1;
        @(negedge clk);
        chk("R9 R8 next lookup returns new", {8'h0, lut_rgb}, {8'h0, m_tab[tgt]});
    endtask

    initial begin
        for (int e = 0; e < 256; e++) m_tab[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
        m_idx = 8'h0; m_ph = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_triplet();
        t_wrap();
        t_restart();
        t_ignored();
        t_reads();
        t_same_cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule